// File: doc/BRIEF.md
# Bidirectional Handshake Port Controller

This block runs one 8-bit peripheral bus in both directions under a handshake. The host writes a byte into an output holding register. The peripheral takes that byte by pulling its acknowledge line low, and the shared pins are driven only while that line stays low. In the other direction, the peripheral pulls its strobe line low to load the pin value into an input holding register, and the host later reads that register. Two flags report the state of each buffer: an active-low output-full flag and an active-high input-full flag.

Each direction has its own interrupt enable. The host sets or clears an enable with a single-bit command that carries a bit index. Both masked conditions are merged into one interrupt request. A status byte gathers the flags, the enables and the interrupt, and passes three bits owned by the neighbouring group through unchanged. A mode-set write returns every flag to its idle value. All host commands are single-cycle pulses that are sampled on the rising clock edge.

Top module: `pbus_bidir_port`

## Requirements
- R1: `pin_oe` is 1 exactly while `ack_n` is 0. `pin_out` always shows the output holding register.
- R2: A `host_wr` pulse loads `host_wdata` into the output register, and `obf_n` is 0 after that edge. With no write in the cycle, `ack_n` low makes `obf_n` 1 after the edge. If a write and a low `ack_n` fall in the same cycle, the write wins.
- R3: `stb_n` low loads `pin_in` into the input register and sets `ibf` after the edge. A `host_rd` pulse while `stb_n` is high clears `ibf`. If a read and a strobe fall in the same cycle, the strobe wins and `ibf` stays 1.
- R4: A strobe and an acknowledge in the same cycle are both accepted. The input register takes the external `pin_in` value, not the byte being driven on `pin_out`.
- R5: The single-bit command (`bit_cmd`, `bit_idx`, `bit_val`) writes the output-side enable when `bit_idx` is 6 and the input-side enable when `bit_idx` is 4. Any other index changes nothing.
- R6: `intr` = (output enable AND `obf_n` AND `ack_n`) OR (input enable AND `ibf`). It follows its terms in the same cycle.
- R7: `status` bit 7 is `obf_n`, bit 6 is the output enable, bit 5 is `ibf`, bit 4 is the input enable, bit 3 is `intr`, and bits 2:0 equal `grp_b_stat`.
- R8: Reset and `mode_set` both set `obf_n` to 1 and clear `ibf` and both enables. `mode_set` takes priority over a strobe, an acknowledge, a write, a read or a bit command in the same cycle.
- R9: `host_rdata` always shows the input holding register. A read does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write of the output byte |
| host_wdata | input | DATA_W | Byte to send to the peripheral |
| host_rd | input | 1 | Host read of the input byte |
| host_rdata | output | DATA_W | Input holding register |
| mode_set | input | 1 | Mode-set write, clears all flags |
| bit_cmd | input | 1 | Single-bit command strobe |
| bit_idx | input | 3 | Bit index of the command |
| bit_val | input | 1 | Value written by the command |
| grp_b_stat | input | 3 | Neighbour group status bits |
| status | output | 8 | Status byte |
| pin_in | input | DATA_W | Value seen on the shared pins |
| pin_out | output | DATA_W | Value driven on the shared pins |
| pin_oe | output | 1 | Drive enable for the shared pins |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| stb_n | input | 1 | Peripheral strobe, active low |
| obf_n | output | 1 | Output buffer full, active low |
| ibf | output | 1 | Input buffer full |
| intr | output | 1 | Combined interrupt request |

## Verification
The interesting collision is an input strobe that arrives while the peripheral is acknowledging, so the pins are being driven. The bench produces it by holding `ack_n` and `stb_n` low in the same cycle. It drives a `pin_in` byte that differs from the byte on `pin_out`. It then checks that `obf_n` rises, that `ibf` sets, and that `host_rdata` holds the external byte. Two further collisions get checked against their stated winners: a write with an acknowledge, and a read with a strobe.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
   localparam int unsigned STAT_W     = 8;
   localparam logic [2:0]  IDX_EN_OUT = 3'd6;
   localparam logic [2:0]  IDX_EN_IN  = 3'd4;
   localparam int unsigned POS_OBF    = 7;
   localparam int unsigned POS_EN_OUT = 6;
   localparam int unsigned POS_IBF    = 5;
   localparam int unsigned POS_EN_IN  = 4;
   localparam int unsigned POS_INTR   = 3;
   localparam int unsigned GRPB_W     = 3;
endpackage

// File: rtl/pbus_out_side.sv
module pbus_out_side #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_set,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              ack_n,
   output logic [DATA_W-1:0] pin_out,
   output logic              pin_oe,
   output logic              obf_n
);
   logic [DATA_W-1:0] out_q;
   logic              obf_n_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q   <= '0;
         obf_n_q <= 1'b1;
      end else if (mode_set) begin
         obf_n_q <= 1'b1;
      end else if (host_wr) begin
         out_q   <= host_wdata;
         obf_n_q <= 1'b0;
      end else if (!ack_n) begin
         obf_n_q <= 1'b1;
      end
   end

   assign pin_out = out_q;
   assign pin_oe  = ~ack_n;
   assign obf_n   = obf_n_q;

   p_obf_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && !mode_set) |=> (!obf_n && pin_out == $past(host_wdata)));
   p_obf_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_n && !host_wr) |=> obf_n);
   p_mode_obf_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mode_set |=> obf_n);
endmodule

// File: rtl/pbus_in_side.sv
module pbus_in_side #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_set,
   input  logic              stb_n,
   input  logic [DATA_W-1:0] pin_in,
   input  logic              host_rd,
   output logic [DATA_W-1:0] in_data,
   output logic              ibf
);
   logic [DATA_W-1:0] in_q;
   logic              ibf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_q  <= '0;
         ibf_q <= 1'b0;
      end else if (mode_set) begin
         ibf_q <= 1'b0;
      end else if (!stb_n) begin
         in_q  <= pin_in;
         ibf_q <= 1'b1;
      end else if (host_rd) begin
         ibf_q <= 1'b0;
      end
   end

   assign in_data = in_q;
   assign ibf     = ibf_q;

   p_stb_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!stb_n && !mode_set) |=> (ibf && in_data == $past(pin_in)));
   p_rd_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && stb_n) |=> !ibf);
   p_rd_keeps_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && stb_n) |=> $stable(in_data));
   p_mode_ibf_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mode_set |=> !ibf);
endmodule

// File: rtl/pbus_irq_ctl.sv
module pbus_irq_ctl #(
   parameter bit INTR_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_set,
   input  logic       bit_cmd,
   input  logic [2:0] bit_idx,
   input  logic       bit_val,
   input  logic       obf_n,
   input  logic       ack_n,
   input  logic       ibf,
   output logic       en_out,
   output logic       en_in,
   output logic       intr
);
   import pbus_pkg::*;

   logic en_out_q, en_in_q, intr_next;

   always_ff @(posedge clk) begin
      if (!rst_n || mode_set) begin
         en_out_q <= 1'b0;
         en_in_q  <= 1'b0;
      end else if (bit_cmd) begin
         if (bit_idx == IDX_EN_OUT) en_out_q <= bit_val;
         if (bit_idx == IDX_EN_IN)  en_in_q  <= bit_val;
      end
   end

   assign en_out    = en_out_q;
   assign en_in     = en_in_q;
   assign intr_next = (en_out_q & obf_n & ack_n) | (en_in_q & ibf);

   generate
      if (INTR_REG) begin : g_intr_reg
         logic intr_q;
         always_ff @(posedge clk) begin
            if (!rst_n) intr_q <= 1'b0;
            else        intr_q <= intr_next;
         end
         assign intr = intr_q;
      end else begin : g_intr_comb
         assign intr = intr_next;
         p_quiet_after_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
            mode_set |=> !intr);
      end
   endgenerate

   p_other_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_cmd && !mode_set && bit_idx != IDX_EN_OUT && bit_idx != IDX_EN_IN)
      |=> ($stable(en_out) && $stable(en_in)));
   p_set_out_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_cmd && !mode_set && bit_idx == IDX_EN_OUT) |=> (en_out == $past(bit_val)));
endmodule

// File: rtl/pbus_bidir_port.sv
module pbus_bidir_port #(
   parameter int unsigned DATA_W   = 8,
   parameter bit          INTR_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              host_rd,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              mode_set,
   input  logic              bit_cmd,
   input  logic [2:0]        bit_idx,
   input  logic              bit_val,
   input  logic [2:0]        grp_b_stat,
   output logic [7:0]        status,
   input  logic [DATA_W-1:0] pin_in,
   output logic [DATA_W-1:0] pin_out,
   output logic              pin_oe,
   input  logic              ack_n,
   input  logic              stb_n,
   output logic              obf_n,
   output logic              ibf,
   output logic              intr
);
   import pbus_pkg::*;

   generate
      if (DATA_W < 1 || DATA_W > 64) begin : g_bad_width
         $error("pbus_bidir_port: DATA_W out of range");
      end
   endgenerate

   logic en_out, en_in;

   pbus_out_side #(.DATA_W(DATA_W)) u_out (
      .clk(clk), .rst_n(rst_n), .mode_set(mode_set),
      .host_wr(host_wr), .host_wdata(host_wdata), .ack_n(ack_n),
      .pin_out(pin_out), .pin_oe(pin_oe), .obf_n(obf_n)
   );

   pbus_in_side #(.DATA_W(DATA_W)) u_in (
      .clk(clk), .rst_n(rst_n), .mode_set(mode_set),
      .stb_n(stb_n), .pin_in(pin_in), .host_rd(host_rd),
      .in_data(host_rdata), .ibf(ibf)
   );

   pbus_irq_ctl #(.INTR_REG(INTR_REG)) u_irq (
      .clk(clk), .rst_n(rst_n), .mode_set(mode_set),
      .bit_cmd(bit_cmd), .bit_idx(bit_idx), .bit_val(bit_val),
      .obf_n(obf_n), .ack_n(ack_n), .ibf(ibf),
      .en_out(en_out), .en_in(en_in), .intr(intr)
   );

   always_comb begin
      status                    = '0;
      status[GRPB_W-1:0]        = grp_b_stat;
      status[POS_INTR]          = intr;
      status[POS_EN_IN]         = en_in;
      status[POS_IBF]           = ibf;
      status[POS_EN_OUT]        = en_out;
      status[POS_OBF]           = obf_n;
   end

   p_both_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_n && !stb_n && !host_wr && !mode_set)
      |=> (obf_n && ibf && host_rdata == $past(pin_in)));
   p_no_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_n) |-> !pin_oe);
endmodule

// File: tb/pbus_bidir_port_tb_top.sv
module pbus_bidir_port_tb_top;
   localparam int DW = 8;
   localparam logic [2:0] GRPB = 3'b101;

   logic clk = 1'b0;
   logic rst_n;
   logic host_wr, host_rd, mode_set, bit_cmd, bit_val, ack_n, stb_n;
   logic [DW-1:0] host_wdata, pin_in, host_rdata, pin_out;
   logic [2:0] bit_idx;
   logic [7:0] status;
   logic pin_oe, obf_n, ibf, intr;
   int n_run = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   pbus_bidir_port #(.DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rd(host_rd), .host_rdata(host_rdata), .mode_set(mode_set),
      .bit_cmd(bit_cmd), .bit_idx(bit_idx), .bit_val(bit_val),
      .grp_b_stat(GRPB), .status(status), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .ack_n(ack_n), .stb_n(stb_n), .obf_n(obf_n),
      .ibf(ibf), .intr(intr)
   );

   typedef struct packed {
      logic       wr;
      logic [7:0] wd;
      logic       rd;
      logic       ack_n;
      logic       stb_n;
      logic [7:0] pin;
      logic       bc;
      logic [2:0] bi;
      logic       bv;
      logic       ms;
      logic [4:0] e_stat;   // {obf_n, en_out, ibf, en_in, intr}
      logic       e_oe;
      logic [7:0] e_pout;
      logic [7:0] e_rd;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      // R5 R6: enable output side, buffer empty and ack high -> intr
      '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00, 1'b1, 3'd6, 1'b1, 1'b0, 5'b11001, 1'b0, 8'h00, 8'h00},
      // R2: write sets obf_n low, intr drops
      '{1'b1, 8'hA5, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 5'b01000, 1'b0, 8'hA5, 8'h00},
      // R1 R2: ack low drives pins and empties the buffer
      '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 5'b11000, 1'b1, 8'hA5, 8'h00},
      // R6: ack released -> intr
      '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 5'b11001, 1'b0, 8'hA5, 8'h00},
      // R5: enable input side
      '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00, 1'b1, 3'd4, 1'b1, 1'b0, 5'b11011, 1'b0, 8'hA5, 8'h00},
      // R3 R9: strobe loads 3C
      '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h3C, 1'b0, 3'd0, 1'b0, 1'b0, 5'b11111, 1'b0, 8'hA5, 8'h3C},
      // R5: disable output side
      '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00, 1'b1, 3'd6, 1'b0, 1'b0, 5'b10111, 1'b0, 8'hA5, 8'h3C},
      // R3 R9: read clears ibf, data stays
      '{1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 5'b10010, 1'b0, 8'hA5, 8'h3C},
      // R5: index 5 has no effect
      '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00, 1'b1, 3'd5, 1'b1, 1'b0, 5'b10010, 1'b0, 8'hA5, 8'h3C},
      // R2: write and ack together, write wins
      '{1'b1, 8'h5A, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 5'b00010, 1'b1, 8'h5A, 8'h3C},
      // R4: ack and strobe together, latch gets C3 not driven 5A
      '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'hC3, 1'b0, 3'd0, 1'b0, 1'b0, 5'b10111, 1'b1, 8'h5A, 8'hC3},
      // R3: read and strobe together, strobe wins
      '{1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h77, 1'b0, 3'd0, 1'b0, 1'b0, 5'b10111, 1'b0, 8'h5A, 8'h77},
      // R8: mode set beats strobe and bit command
      '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h99, 1'b1, 3'd4, 1'b1, 1'b1, 5'b10000, 1'b0, 8'h5A, 8'h77}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle();
      host_wr = 0; host_wdata = '0; host_rd = 0; mode_set = 0;
      bit_cmd = 0; bit_idx = '0; bit_val = 0; ack_n = 1; stb_n = 1; pin_in = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      idle();
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      #1;
      // R8 R7 R1: reset state
      check("R8 reset status", {24'd0, status}, {24'd0, 5'b10000, GRPB});
      check("R1 reset oe", {31'd0, pin_oe}, 32'd0);
      check("R9 reset rdata", {24'd0, host_rdata}, 32'd0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         host_wr = VECS[i].wr; host_wdata = VECS[i].wd; host_rd = VECS[i].rd;
         ack_n = VECS[i].ack_n; stb_n = VECS[i].stb_n; pin_in = VECS[i].pin;
         bit_cmd = VECS[i].bc; bit_idx = VECS[i].bi; bit_val = VECS[i].bv;
         mode_set = VECS[i].ms;
         @(posedge clk);
         #2;
         check("R7 status", {24'd0, status}, {24'd0, VECS[i].e_stat, GRPB});
         check("R1 pin_oe", {31'd0, pin_oe}, {31'd0, VECS[i].e_oe});
         check("R1 pin_out", {24'd0, pin_out}, {24'd0, VECS[i].e_pout});
         check("R9 host_rdata", {24'd0, host_rdata}, {24'd0, VECS[i].e_rd});
         check("R6 intr", {31'd0, intr}, {31'd0, VECS[i].e_stat[0]});
      end

      // R2 R8: write then reset mid-transfer
      @(negedge clk); idle(); host_wr = 1; host_wdata = 8'h11;
      @(posedge clk); #2;
      check("R2 obf_n after write", {31'd0, obf_n}, 32'd0);
      @(negedge clk); idle(); rst_n = 0;
      @(posedge clk); #2;
      check("R8 obf_n after reset", {31'd0, obf_n}, 32'd1);
      check("R8 ibf after reset", {31'd0, ibf}, 32'd0);
      @(negedge clk); rst_n = 1;
      // R6: input enable with ibf raises intr in the same cycle as the status
      @(negedge clk); bit_cmd = 1; bit_idx = 3'd4; bit_val = 1;
      @(posedge clk); #2;
      check("R6 intr idle", {31'd0, intr}, 32'd0);
      @(negedge clk); idle(); stb_n = 0; pin_in = 8'hE1;
      @(posedge clk); #2;
      check("R3 ibf set", {31'd0, ibf}, 32'd1);
      check("R6 intr from ibf", {31'd0, intr}, 32'd1);
      check("R3 data E1", {24'd0, host_rdata}, 32'h0000_00E1);
      @(negedge clk); idle();

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule